// File: doc/BRIEF.md
# User-Level Interrupt Control Register Unit

This unit serves the user-level interrupt control registers of a RISC-V style hart behind a simple CSR port. The port carries a 12-bit address, write data and a write strobe. The unit answers with read data in the same cycle and a hit flag. When the flag is low, the access belongs to somebody else and an outer decoder handles it. The unit owns five user-only registers: the trap vector base, the scratch word, the exception PC, the cause and the trap value.

The user status, user interrupt-enable and user interrupt-pending registers have no storage of their own. They are windows onto three wider shared words (status, enable and pending) that live in this unit. The supervisor-to-user delegation mask, an input, filters what each window shows and what it may change. Machine and supervisor logic load the shared words through a separate full-word write port, and they see those words on outputs.

Top module: `user_irq_csr`

## Requirements
- R1: Only the addresses 0x000 (user status), 0x004 (user enable), 0x005 (trap vector), 0x040 (scratch), 0x041 (exception PC), 0x042 (cause), 0x043 (trap value) and 0x044 (user pending) raise `csr_hit`. Every other address gives `csr_hit`=0 and `csr_rdata`=0, and a write to it changes nothing.
- R2: While `umode_present` is 0, every address misses, reads return 0 and writes change no state.
- R3: A read of user status returns shared status bit 4 at bit 4 and shared status bit 0 at bit 0. All other bits read as 0.
- R4: A write to user status replaces only bits 4 and 0 of the shared status word. All other status bits keep their value.
- R5: A read of user enable or user pending returns, at bits 8 (external), 4 (timer) and 0 (software), the shared enable or pending bit ANDed with the same bit of `deleg`. All other bits read as 0.
- R6: A write to user enable replaces each of shared enable bits 8, 4 and 0 only where `deleg` has that bit set. Every other enable bit keeps its value.
- R7: A write to user pending can change only shared pending bit 0, and only when `deleg[0]` is 1. Pending bits 8 and 4, and all others, cannot be written this way.
- R8: Scratch, exception PC, cause and trap value store the whole written word and read it back unchanged.
- R9: A trap vector write stores bits XLEN-1..2 as written. Mode bits 1..0 take the written value when it is 0 (direct) or 1 (vectored). A written mode of 2 or 3 keeps the previous mode.
- R10: Synchronous reset clears all five user registers and the shared status, enable and pending words to 0.
- R11: A `shr_we` pulse loads `shr_wdata` whole into the shared word chosen by `shr_sel` (0 status, 1 enable, 2 pending, 3 none). In a cycle where it targets the same word as a CSR write, the shared-port value is stored and the CSR write to that word is dropped.
- R12: Reads are combinational in the address and have no side effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| umode_present | input | 1 | Configuration: user mode is implemented |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_we | input | 1 | CSR write strobe |
| csr_rdata | output | XLEN | CSR read data, same cycle |
| csr_hit | output | 1 | Address belongs to this unit |
| deleg | input | XLEN | Supervisor-to-user interrupt delegation mask |
| shr_we | input | 1 | Full-word write to a shared word |
| shr_sel | input | 2 | Shared word target: 0 status, 1 enable, 2 pending |
| shr_wdata | input | XLEN | Shared-word write data |
| shr_status | output | XLEN | Shared status word |
| shr_ie | output | XLEN | Shared interrupt-enable word |
| shr_ip | output | XLEN | Shared interrupt-pending word |

## Verification
The bench builds the unit with its default XLEN of 64. That brings the upper halves of the full-width registers into reach, as well as shared status bits far above the two bits the user view exposes, so a view that leaks or a merge that clobbers neighbouring bits shows up on the shared outputs. The delegation mask is set to delegate external and software interrupts while withholding the timer. This lets a single sequence separate delegated from withheld bits in both the enable and the pending paths. A later run then withdraws software delegation to show that user pending writes are locked out.

// File: rtl/uic_pkg.sv
package uic_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] ADR_STATUS  = 12'h000;
    localparam logic [ADDR_W-1:0] ADR_IE      = 12'h004;
    localparam logic [ADDR_W-1:0] ADR_TVEC    = 12'h005;
    localparam logic [ADDR_W-1:0] ADR_SCRATCH = 12'h040;
    localparam logic [ADDR_W-1:0] ADR_EPC     = 12'h041;
    localparam logic [ADDR_W-1:0] ADR_CAUSE   = 12'h042;
    localparam logic [ADDR_W-1:0] ADR_TVAL    = 12'h043;
    localparam logic [ADDR_W-1:0] ADR_IP      = 12'h044;

    // status view bit positions
    localparam int ST_PRIOR_EN_BIT = 4;
    localparam int ST_EN_BIT       = 0;
    // interrupt view bit positions
    localparam int IRQ_EXT_BIT = 8;
    localparam int IRQ_TMR_BIT = 4;
    localparam int IRQ_SW_BIT  = 0;

    localparam int NUM_SHARED = 3;
    localparam int NUM_PLAIN  = 4;

    // the four plain registers must stay consecutive
    typedef enum logic [3:0] {
        SEL_NONE    = 4'd0,
        SEL_STATUS  = 4'd1,
        SEL_IE      = 4'd2,
        SEL_IP      = 4'd3,
        SEL_TVEC    = 4'd4,
        SEL_SCRATCH = 4'd5,
        SEL_EPC     = 4'd6,
        SEL_CAUSE   = 4'd7,
        SEL_TVAL    = 4'd8
    } csr_sel_e;

    typedef enum logic [1:0] {
        SHR_STATUS = 2'd0,
        SHR_IE     = 2'd1,
        SHR_IP     = 2'd2,
        SHR_NONE   = 2'd3
    } shr_sel_e;

    function automatic csr_sel_e addr_to_sel(input logic [ADDR_W-1:0] a);
        csr_sel_e s;
        case (a)
            ADR_STATUS:  s = SEL_STATUS;
            ADR_IE:      s = SEL_IE;
            ADR_IP:      s = SEL_IP;
            ADR_TVEC:    s = SEL_TVEC;
            ADR_SCRATCH: s = SEL_SCRATCH;
            ADR_EPC:     s = SEL_EPC;
            ADR_CAUSE:   s = SEL_CAUSE;
            ADR_TVAL:    s = SEL_TVAL;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    // shared word that each view selector writes, SHR_NONE if not a view
    function automatic shr_sel_e view_target(input csr_sel_e s);
        shr_sel_e t;
        case (s)
            SEL_STATUS: t = SHR_STATUS;
            SEL_IE:     t = SHR_IE;
            SEL_IP:     t = SHR_IP;
            default:    t = SHR_NONE;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/uic_addr_decode.sv
module uic_addr_decode
    import uic_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              umode_present,
    output csr_sel_e          sel,
    output logic              hit
);

    csr_sel_e raw_sel;

    always_comb begin
        raw_sel = addr_to_sel(addr);
        sel     = umode_present ? raw_sel : SEL_NONE;
        hit     = (sel != SEL_NONE);
    end

endmodule

// File: rtl/uic_shared_view.sv
module uic_shared_view
    import uic_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  csr_sel_e        sel,
    input  logic            wr,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] deleg,
    input  logic            shr_we,
    input  logic [1:0]      shr_sel,
    input  logic [XLEN-1:0] shr_wdata,
    output logic [XLEN-1:0] status_q,
    output logic [XLEN-1:0] ie_q,
    output logic [XLEN-1:0] ip_q,
    output logic [XLEN-1:0] status_view,
    output logic [XLEN-1:0] ie_view,
    output logic [XLEN-1:0] ip_view
);

    localparam logic [XLEN-1:0] STATUS_MASK =
        (XLEN'(1) << ST_PRIOR_EN_BIT) | (XLEN'(1) << ST_EN_BIT);
    localparam logic [XLEN-1:0] IRQ_MASK =
        (XLEN'(1) << IRQ_EXT_BIT) | (XLEN'(1) << IRQ_TMR_BIT) | (XLEN'(1) << IRQ_SW_BIT);
    localparam logic [XLEN-1:0] SW_MASK = XLEN'(1) << IRQ_SW_BIT;

    logic [XLEN-1:0] word_q   [NUM_SHARED];
    logic [XLEN-1:0] wmask    [NUM_SHARED];
    logic [XLEN-1:0] deleg_irq;
    shr_sel_e        csr_tgt;

    always_comb begin
        deleg_irq = deleg & IRQ_MASK;
        csr_tgt   = wr ? view_target(sel) : SHR_NONE;
        wmask[SHR_STATUS] = STATUS_MASK;
        wmask[SHR_IE]     = deleg_irq;
        wmask[SHR_IP]     = deleg & SW_MASK;
    end

    for (genvar gi = 0; gi < NUM_SHARED; gi++) begin : g_word
        logic ext_hit;
        logic csr_hit_w;
        assign ext_hit   = shr_we && (shr_sel == 2'(gi));
        assign csr_hit_w = (csr_tgt == shr_sel_e'(gi));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[gi] <= '0;
            end else if (ext_hit) begin
                word_q[gi] <= shr_wdata;
            end else if (csr_hit_w) begin
                word_q[gi] <= (word_q[gi] & ~wmask[gi]) | (wdata & wmask[gi]);
            end
        end
    end

    assign status_q    = word_q[SHR_STATUS];
    assign ie_q        = word_q[SHR_IE];
    assign ip_q        = word_q[SHR_IP];
    assign status_view = status_q & STATUS_MASK;
    assign ie_view     = ie_q & deleg_irq;
    assign ip_view     = ip_q & deleg_irq;

    // R4
    status_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_STATUS && !(shr_we && shr_sel == 2'(SHR_STATUS)))
        |=> ((status_q & ~STATUS_MASK) == $past(status_q & ~STATUS_MASK)));

    // R6
    ie_undeleg_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_IE && !(shr_we && shr_sel == 2'(SHR_IE)))
        |=> ((ie_q & ~IRQ_MASK) == $past(ie_q & ~IRQ_MASK)) &&
            ((ie_q & IRQ_MASK & ~deleg) == $past(ie_q & IRQ_MASK & ~deleg)));

    // R7
    ip_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_IP && !(shr_we && shr_sel == 2'(SHR_IP)))
        |=> ((ip_q & ~SW_MASK) == $past(ip_q & ~SW_MASK)));

    // R11
    shr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (shr_we && shr_sel == 2'(SHR_STATUS)) |=> (status_q == $past(shr_wdata)));

endmodule

// File: rtl/uic_trap_regs.sv
module uic_trap_regs
    import uic_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  csr_sel_e        sel,
    input  logic            wr,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] tvec_q,
    output logic [XLEN-1:0] plain_q [NUM_PLAIN]
);

    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_MAX = 2'd1;

    logic [MODE_W-1:0] mode_next;

    always_comb begin
        mode_next = (wdata[MODE_W-1:0] > MODE_MAX) ? tvec_q[MODE_W-1:0] : wdata[MODE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tvec_q <= '0;
        end else if (wr && sel == SEL_TVEC) begin
            tvec_q <= {wdata[XLEN-1:MODE_W], mode_next};
        end
    end

    for (genvar gi = 0; gi < NUM_PLAIN; gi++) begin : g_plain
        localparam csr_sel_e MY_SEL = csr_sel_e'(int'(SEL_SCRATCH) + gi);
        always_ff @(posedge clk) begin
            if (rst) begin
                plain_q[gi] <= '0;
            end else if (wr && sel == MY_SEL) begin
                plain_q[gi] <= wdata;
            end
        end
    end

    // R9
    tvec_mode_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_TVEC && wdata[1])
        |=> (tvec_q[1:0] == $past(tvec_q[1:0])));

    // R8
    scratch_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_SCRATCH) |=> (plain_q[0] == $past(wdata)));

endmodule

// File: rtl/user_irq_csr.sv
module user_irq_csr
    import uic_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              umode_present,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic              csr_we,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_hit,
    input  logic [XLEN-1:0]   deleg,
    input  logic              shr_we,
    input  logic [1:0]        shr_sel,
    input  logic [XLEN-1:0]   shr_wdata,
    output logic [XLEN-1:0]   shr_status,
    output logic [XLEN-1:0]   shr_ie,
    output logic [XLEN-1:0]   shr_ip
);

    csr_sel_e        sel;
    logic            hit;
    logic            wr;
    logic [XLEN-1:0] status_view, ie_view, ip_view;
    logic [XLEN-1:0] tvec_q;
    logic [XLEN-1:0] plain_q [NUM_PLAIN];

    uic_addr_decode u_dec (
        .addr          (csr_addr),
        .umode_present (umode_present),
        .sel           (sel),
        .hit           (hit)
    );

    assign wr = csr_we && hit;

    uic_shared_view #(.XLEN(XLEN)) u_view (
        .clk         (clk),
        .rst         (rst),
        .sel         (sel),
        .wr          (wr),
        .wdata       (csr_wdata),
        .deleg       (deleg),
        .shr_we      (shr_we),
        .shr_sel     (shr_sel),
        .shr_wdata   (shr_wdata),
        .status_q    (shr_status),
        .ie_q        (shr_ie),
        .ip_q        (shr_ip),
        .status_view (status_view),
        .ie_view     (ie_view),
        .ip_view     (ip_view)
    );

    uic_trap_regs #(.XLEN(XLEN)) u_trap (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .wr      (wr),
        .wdata   (csr_wdata),
        .tvec_q  (tvec_q),
        .plain_q (plain_q)
    );

    always_comb begin
        case (sel)
            SEL_STATUS:  csr_rdata = status_view;
            SEL_IE:      csr_rdata = ie_view;
            SEL_IP:      csr_rdata = ip_view;
            SEL_TVEC:    csr_rdata = tvec_q;
            SEL_SCRATCH: csr_rdata = plain_q[0];
            SEL_EPC:     csr_rdata = plain_q[1];
            SEL_CAUSE:   csr_rdata = plain_q[2];
            SEL_TVAL:    csr_rdata = plain_q[3];
            default:     csr_rdata = '0;
        endcase
        csr_hit = hit;
    end

    // R2
    no_umode_miss_chk: assert property (@(posedge clk) disable iff (rst)
        !umode_present |-> !csr_hit);

    // R1
    miss_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !csr_hit |-> (csr_rdata == '0));

    // R12
    read_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (!csr_we && !shr_we) |=> ($stable(shr_status) && $stable(shr_ie) &&
                                  $stable(shr_ip) && $stable(tvec_q)));

endmodule

// File: tb/tb_user_irq_csr.sv
module tb_user_irq_csr;

    localparam int XLEN = 64;
    localparam logic [XLEN-1:0] ONES = '1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            umode_present = 1'b1;
    logic [11:0]     csr_addr = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic            csr_we = 1'b0;
    logic [XLEN-1:0] csr_rdata;
    logic            csr_hit;
    logic [XLEN-1:0] deleg = '0;
    logic            shr_we = 1'b0;
    logic [1:0]      shr_sel = '0;
    logic [XLEN-1:0] shr_wdata = '0;
    logic [XLEN-1:0] shr_status, shr_ie, shr_ip;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    user_irq_csr #(.XLEN(XLEN)) dut (.*);

    always #4 clk = ~clk;

    typedef struct packed {
        logic [11:0]     addr;
        logic [XLEN-1:0] wdata;
        logic [XLEN-1:0] exp_rd;
        logic [1:0]      sh_kind;   // 0 none, 1 status, 2 enable, 3 pending
        logic [XLEN-1:0] exp_sh;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{12'h040, 64'hDEADBEEF_CAFEF00D, 64'hDEADBEEF_CAFEF00D, 2'd0, 64'h0},            // R8
        '{12'h041, 64'h80000000_00001234, 64'h80000000_00001234, 2'd0, 64'h0},            // R8
        '{12'h042, 64'h80000000_00000008, 64'h80000000_00000008, 2'd0, 64'h0},            // R8
        '{12'h043, 64'h01234567_89ABCDEF, 64'h01234567_89ABCDEF, 2'd0, 64'h0},            // R8
        '{12'h005, 64'h00000000_10000001, 64'h00000000_10000001, 2'd0, 64'h0},            // R9
        '{12'h005, 64'h00000000_20000003, 64'h00000000_20000001, 2'd0, 64'h0},            // R9
        '{12'h005, 64'h00000000_30000000, 64'h00000000_30000000, 2'd0, 64'h0},            // R9
        '{12'h005, 64'h00000000_40000002, 64'h00000000_40000000, 2'd0, 64'h0},            // R9
        '{12'h000, 64'h0,                 64'h0,                 2'd1, 64'hFFFFFFFF_FFFFFFEE}, // R4
        '{12'h000, 64'hFFFFFFFF_FFFFFFFF, 64'h11,                2'd1, 64'hFFFFFFFF_FFFFFFFF}, // R3
        '{12'h004, 64'h0,                 64'h0,                 2'd2, 64'h010},           // R6
        '{12'h004, 64'hFFFFFFFF_FFFFFFFF, 64'h101,               2'd2, 64'h111},           // R5
        '{12'h044, 64'hFFFFFFFF_FFFFFFFF, 64'h001,               2'd3, 64'h001},           // R7
        '{12'h044, 64'h0,                 64'h0,                 2'd3, 64'h0}              // R7
    };

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [XLEN-1:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic shr_wr(input logic [1:0] s, input logic [XLEN-1:0] d);
        @(negedge clk);
        shr_sel = s; shr_wdata = d; shr_we = 1'b1;
        @(negedge clk);
        shr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [11:0] a, output logic [XLEN-1:0] d, output logic h);
        csr_addr = a;
        #1;
        d = csr_rdata;
        h = csr_hit;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] rd;
        logic            h;
        logic [11:0]     hit_addrs [8];
        logic [11:0]     miss_addrs [5];
        hit_addrs  = '{12'h000, 12'h004, 12'h005, 12'h040, 12'h041, 12'h042, 12'h043, 12'h044};
        miss_addrs = '{12'h001, 12'h003, 12'h045, 12'h100, 12'hC00};

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state and R1 hits
        for (int i = 0; i < 8; i++) begin
            csr_rd(hit_addrs[i], rd, h);
            check("R10 reset read", rd, '0);
            check("R1 hit", XLEN'(h), XLEN'(1));
        end
        check("R10 shared status", shr_status, '0);
        check("R10 shared ie", shr_ie, '0);
        check("R10 shared ip", shr_ip, '0);

        // preload shared state
        deleg = 64'h101;
        shr_wr(2'd0, ONES);
        shr_wr(2'd1, 64'h110);
        check("R11 shared load", shr_status, ONES);
        check("R11 shared load ie", shr_ie, 64'h110);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            csr_wr(VECS[i].addr, VECS[i].wdata);
            csr_rd(VECS[i].addr, rd, h);
            check($sformatf("vector %0d readback (R3-R9 table)", i), rd, VECS[i].exp_rd);
            case (VECS[i].sh_kind)
                2'd1: check($sformatf("vector %0d shared status", i), shr_status, VECS[i].exp_sh);
                2'd2: check($sformatf("vector %0d shared ie", i), shr_ie, VECS[i].exp_sh);
                2'd3: check($sformatf("vector %0d shared ip", i), shr_ip, VECS[i].exp_sh);
                default: ;
            endcase
        end

        // R1 misses: zero data, writes ignored
        for (int i = 0; i < 5; i++) begin
            csr_wr(miss_addrs[i], ONES);
            csr_rd(miss_addrs[i], rd, h);
            check("R1 miss hit", XLEN'(h), '0);
            check("R1 miss data", rd, '0);
        end
        csr_rd(12'h040, rd, h);
        check("R1 miss write no effect", rd, 64'hDEADBEEF_CAFEF00D);

        // R2 user mode absent
        umode_present = 1'b0;
        csr_wr(12'h040, 64'h5555);
        csr_rd(12'h040, rd, h);
        check("R2 no umode hit", XLEN'(h), '0);
        check("R2 no umode data", rd, '0);
        csr_wr(12'h000, 64'h0);
        check("R2 status untouched", shr_status, ONES);
        umode_present = 1'b1;
        csr_rd(12'h040, rd, h);
        check("R2 write ignored", rd, 64'hDEADBEEF_CAFEF00D);

        // R7 software bit undelegated: pending locked
        deleg = 64'h100;
        shr_wr(2'd2, 64'h111);
        csr_wr(12'h044, 64'h0);
        check("R7 undelegated ip", shr_ip, 64'h111);
        csr_rd(12'h044, rd, h);
        check("R5 ip view", rd, 64'h100);
        deleg = 64'h0;
        csr_rd(12'h004, rd, h);
        check("R5 ie view no deleg", rd, '0);

        // R11 priority over same-cycle CSR write
        @(negedge clk);
        shr_sel = 2'd0; shr_wdata = 64'h0; shr_we = 1'b1;
        csr_addr = 12'h000; csr_wdata = ONES; csr_we = 1'b1;
        @(negedge clk);
        shr_we = 1'b0; csr_we = 1'b0;
        check("R11 priority", shr_status, '0);

        // R12 repeated reads leave state alone
        csr_rd(12'h043, rd, h);
        csr_rd(12'h043, rd, h);
        check("R12 read stable", rd, 64'h01234567_89ABCDEF);

        // R10 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        csr_rd(12'h005, rd, h);
        check("R10 tvec cleared", rd, '0);
        csr_rd(12'h041, rd, h);
        check("R10 epc cleared", rd, '0);
        check("R10 ip cleared", shr_ip, '0);
        check("R10 ie cleared", shr_ie, '0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule